// File: doc/BRIEF.md
# Fault-Tolerant Virtual-Channel Allocator

This block assigns downstream virtual channels to packets in one five-port mesh router with four virtual channels per input port. Each input VC whose head flit has finished route computation raises a request that names its output port. A separable two-stage scheme then runs. In the first stage, each requesting VC's own round-robin arbiter set picks one free downstream VC of that output port. In the second stage, one round-robin arbiter per downstream VC resolves contention among the input VCs that picked it. Grants are combinational in the request cycle and carry the downstream VC number.

The allocator keeps working when an arbiter is stuck. An input VC whose first-stage arbiter set is flagged faulty borrows the set of a sibling VC in the same input port. A sibling can lend only when its set is healthy, its pipeline state is not virtual-channel allocation, and it is not requesting in that cycle. When no sibling can lend, the VC is stalled for the cycle. A flagged second-stage arbiter never grants its downstream VC. A request that picked that VC is told to retry, and from the next cycle that VC is removed from first-stage candidate selection. A granted downstream VC stays busy until a tail-flit release pulse frees it.

Top module: `va_alloc_ft`

## Requirements
- R1: An input VC i (index = input port × 4 + local VC) that requests output port o (field `req_port[3i+2:3i]`) is granted in the same cycle. In the fault-free case it receives the first free downstream VC found by scanning cyclically upward from its arbiter set's pointer, reported on `gnt_dvc[2i+1:2i]`. After a grant, that pointer moves to one past the chosen VC, wrapping modulo 4.
- R2: When several input VCs pick the same downstream VC, the winner is the first requester at or cyclically after that downstream arbiter's pointer, scanning over input indices 0 to 19. After a grant the pointer moves one past the winner. Each loser raises `retry`.
- R3: Downstream VC d (index = output port × 4 + VC) becomes busy from the cycle after its grant. It is not offered again until a pulse on `dvc_release[d]`, which takes effect in the following cycle. A release for a VC that is not busy has no effect.
- R4: Each downstream VC is granted to at most one input VC per cycle. A grant appears only for a requesting VC. Every requesting VC shows exactly one of grant, stall or retry.
- R5: A requesting VC whose first-stage set is flagged in `s1_fault` borrows the set of the lowest-indexed sibling in its input port that meets three conditions: its set is healthy, its `vc_stage` is not 2'b10 (allocation), and it is not requesting. Lower-indexed borrowers choose first, and each lender serves one borrower. The lender's pointer is used for the pick and advances on the grant.
- R6: A VC with a flagged set and no eligible lender raises `stall` and gets no grant in that cycle. A sibling that is itself requesting keeps its own set.
- R7: A downstream VC whose `s2_fault` bit is high is never granted. In the first cycle of the flag a request may still pick it and then raises `retry`. From the next cycle that VC is excluded from first-stage selection, so the retry picks another free VC of the same output port.
- R8: With all fault flags low, grants, downstream VC numbers, stalls and retries match a fault-free separable round-robin allocator cycle for cycle under arbitrary traffic.
- R9: After reset, all downstream VCs are free, all pointers are zero, and no grant, stall or retry appears without a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_vld | input | 20 | Per input VC: head flit ready for allocation |
| req_port | input | 60 | Per input VC: requested output port, 3 bits each |
| vc_stage | input | 40 | Per input VC pipeline state, 2 bits each (00 idle, 01 routing, 10 allocation, 11 active) |
| s1_fault | input | 20 | Per input VC: first-stage arbiter set faulty |
| s2_fault | input | 20 | Per downstream VC: second-stage arbiter faulty |
| dvc_release | input | 20 | Per downstream VC: tail-flit release pulse |
| gnt_vld | output | 20 | Per input VC: allocation granted this cycle |
| gnt_dvc | output | 40 | Per input VC: granted downstream VC number, 2 bits each |
| stall | output | 20 | Per input VC: faulty set and no lender this cycle |
| retry | output | 20 | Per input VC: request not granted, try again next cycle |

## Verification
The assertions check several properties on every cycle:
- no downstream VC goes to two input VCs at once;
- no grant appears without a request;
- every request has exactly one outcome;
- a stall occurs only with a flagged set;
- a flagged second-stage arbiter stays silent;
- a held downstream VC is never granted again before its release.

Only the bench scenarios can show the timing and choice behaviour:
- the round-robin order;
- the one-cycle delay before a release or a second-stage fault mask takes effect;
- which sibling lends its set, and that the lender's pointer moves;
- exact agreement with the fault-free reference under random traffic.

// File: rtl/va_alloc_pkg.sv
// Shared constants and the cyclic first-match search used by every
// round-robin arbiter of the allocator. Assumes arbiter widths of at most 32.
package va_alloc_pkg;

    localparam logic [1:0] ST_VALLOC = 2'b10;

    // Index of the first set bit of mask at or cyclically after ptr, or n if none.
    function automatic int rr_first(input logic [31:0] mask, input int ptr, input int n);
        int idx;
        rr_first = n;
        for (int k = 31; k >= 0; k--) begin
            if (k < n) begin
                idx = ptr + k;
                if (idx >= n) idx = idx - n;
                if (mask[idx]) rr_first = idx;
            end
        end
    endfunction

endpackage

// File: rtl/va_lender_map.sv
// Chooses, for each VC of one input port, which first-stage arbiter set it
// uses this cycle. Healthy VCs keep their own set. A requesting VC with a
// faulty set takes the lowest-indexed sibling set that is healthy, idle
// (stage not allocation) and not requested. Assumes lower-indexed borrowers
// have precedence. Purely combinational.
module va_lender_map
    import va_alloc_pkg::*;
#(
    parameter int NVC = 4,
    parameter int VCW = 2
) (
    input  logic [NVC-1:0]     set_fault,
    input  logic [NVC-1:0]     req,
    input  logic [2*NVC-1:0]   stage,
    output logic [NVC*VCW-1:0] use_set,
    output logic [NVC-1:0]     set_ok
);

    logic [NVC-1:0] taken;

    // Assign each VC its own set or a lender, one borrower per lender.
    always_comb begin
        taken   = '0;
        use_set = '0;
        set_ok  = '0;
        for (int v = 0; v < NVC; v++) begin
            if (!set_fault[v]) begin
                use_set[v*VCW +: VCW] = VCW'(v);
                set_ok[v]             = 1'b1;
            end else if (req[v]) begin
                for (int u = 0; u < NVC; u++) begin
                    if (!set_ok[v] && (u != v) && !set_fault[u] &&
                        (stage[u*2 +: 2] != ST_VALLOC) && !req[u] && !taken[u]) begin
                        use_set[v*VCW +: VCW] = VCW'(u);
                        set_ok[v]             = 1'b1;
                        taken[u]              = 1'b1;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/va_stage1_pick.sv
// First-stage round-robin pick: the first candidate downstream VC at or
// cyclically after the pointer of the arbiter set in use. The pointer is
// owned by the caller. Purely combinational.
module va_stage1_pick
    import va_alloc_pkg::*;
#(
    parameter int NVC = 4,
    parameter int VCW = 2
) (
    input  logic [NVC-1:0] cand,
    input  logic [VCW-1:0] ptr,
    output logic           found,
    output logic [VCW-1:0] idx
);

    int hit;

    // Scan candidates cyclically from the pointer.
    always_comb begin
        hit   = rr_first(32'(cand), int'(ptr), NVC);
        found = (hit < NVC);
        idx   = found ? VCW'(hit) : '0;
    end

endmodule

// File: rtl/va_stage2_arb.sv
// Second-stage round-robin arbiter for one downstream VC. It grants one of
// the input VCs that picked this VC, unless its fault flag is high, and
// keeps its own pointer, which moves one past the winner on each grant.
module va_stage2_arb
    import va_alloc_pkg::*;
#(
    parameter int NIN = 20,
    parameter int INW = 5
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NIN-1:0] req,
    input  logic           fault,
    output logic [NIN-1:0] gnt,
    output logic           any
);

    logic [INW-1:0] ptr_q;
    int             win;

    // Pick the winner; a faulty arbiter never grants.
    always_comb begin
        win = rr_first(32'(req), int'(ptr_q), NIN);
        gnt = '0;
        any = 1'b0;
        if (!fault && (win < NIN)) begin
            gnt[win] = 1'b1;
            any      = 1'b1;
        end
    end

    // Advance the pointer past the winner.
    always_ff @(posedge clk) begin
        if (!rst_n)   ptr_q <= '0;
        else if (any) ptr_q <= (win == NIN - 1) ? '0 : INW'(win + 1);
    end

endmodule

// File: rtl/va_alloc_ft.sv
// Two-stage separable virtual-channel allocator with arbiter fault tolerance
// for one router (NPORT ports x NVC VCs). Grants are combinational in the
// request cycle. Assumes requests are held by the input VC until granted,
// fault flags come from an external detector, and release pulses come from
// tail-flit departure.
module va_alloc_ft
    import va_alloc_pkg::*;
#(
    parameter int NPORT = 5,
    parameter int NVC   = 4
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [NPORT*NVC-1:0]            req_vld,
    input  logic [NPORT*NVC*$clog2(NPORT)-1:0] req_port,
    input  logic [NPORT*NVC*2-1:0]          vc_stage,
    input  logic [NPORT*NVC-1:0]            s1_fault,
    input  logic [NPORT*NVC-1:0]            s2_fault,
    input  logic [NPORT*NVC-1:0]            dvc_release,
    output logic [NPORT*NVC-1:0]            gnt_vld,
    output logic [NPORT*NVC*((NVC > 1) ? $clog2(NVC) : 1)-1:0] gnt_dvc,
    output logic [NPORT*NVC-1:0]            stall,
    output logic [NPORT*NVC-1:0]            retry
);

    localparam int NIN = NPORT * NVC;
    localparam int PW  = $clog2(NPORT);
    localparam int VCW = (NVC > 1) ? $clog2(NVC) : 1;
    localparam int INW = $clog2(NIN);

    logic [NIN-1:0]     busy_q;
    logic [NIN-1:0]     s2_seen_q;
    logic [VCW-1:0]     ptr1_q [NIN];
    logic [NIN*VCW-1:0] use_loc;
    logic [NIN-1:0]     set_ok;
    logic [NIN*INW-1:0] set_g;
    logic [NIN*VCW-1:0] pick;
    logic [NIN*INW-1:0] target;
    logic [NIN-1:0]     s1_go;
    logic [NIN*NIN-1:0] s2_gnt;
    logic [NIN-1:0]     dvc_taken;

    // Per input port: decide which arbiter set each VC uses.
    for (genvar p = 0; p < NPORT; p++) begin : g_port
        va_lender_map #(.NVC(NVC), .VCW(VCW)) u_lend (
            .set_fault (s1_fault[p*NVC +: NVC]),
            .req       (req_vld[p*NVC +: NVC]),
            .stage     (vc_stage[p*2*NVC +: 2*NVC]),
            .use_set   (use_loc[p*NVC*VCW +: NVC*VCW]),
            .set_ok    (set_ok[p*NVC +: NVC])
        );
    end

    // Per input VC: candidate mask, first-stage pick and outcome signals.
    for (genvar i = 0; i < NIN; i++) begin : g_in
        localparam int PORT_BASE = (i / NVC) * NVC;
        logic [PW-1:0]  op;
        logic [NVC-1:0] cand;
        logic           found;

        assign op = req_port[i*PW +: PW];

        // Free, non-masked downstream VCs of the requested output port.
        always_comb begin
            cand = '0;
            if (int'(op) < NPORT)
                cand = ~(busy_q[int'(op)*NVC +: NVC] | s2_seen_q[int'(op)*NVC +: NVC]);
        end

        assign set_g[i*INW +: INW] = INW'(PORT_BASE + int'(use_loc[i*VCW +: VCW]));

        va_stage1_pick #(.NVC(NVC), .VCW(VCW)) u_pick (
            .cand  (cand),
            .ptr   (ptr1_q[set_g[i*INW +: INW]]),
            .found (found),
            .idx   (pick[i*VCW +: VCW])
        );

        assign s1_go[i]               = req_vld[i] & set_ok[i] & found;
        assign target[i*INW +: INW]   = INW'(int'(op) * NVC + int'(pick[i*VCW +: VCW]));
        assign gnt_dvc[i*VCW +: VCW]  = gnt_vld[i] ? pick[i*VCW +: VCW] : '0;
        assign stall[i]               = req_vld[i] & ~set_ok[i];
        assign retry[i]               = req_vld[i] & set_ok[i] & ~gnt_vld[i];
    end

    // Per downstream VC: gather pickers and arbitrate.
    for (genvar d = 0; d < NIN; d++) begin : g_dvc
        logic [NIN-1:0] rq;

        // Input VCs whose first-stage pick is this downstream VC.
        always_comb begin
            for (int i = 0; i < NIN; i++)
                rq[i] = s1_go[i] && (target[i*INW +: INW] == INW'(d));
        end

        va_stage2_arb #(.NIN(NIN), .INW(INW)) u_arb (
            .clk   (clk),
            .rst_n (rst_n),
            .req   (rq),
            .fault (s2_fault[d]),
            .gnt   (s2_gnt[d*NIN +: NIN]),
            .any   (dvc_taken[d])
        );
    end

    // Fold second-stage grants back onto input VCs.
    always_comb begin
        gnt_vld = '0;
        for (int d = 0; d < NIN; d++)
            gnt_vld = gnt_vld | s2_gnt[d*NIN +: NIN];
    end

    // Advance the pointer of the arbiter set used by each granted VC.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < NIN; s++) ptr1_q[s] <= '0;
        end else begin
            for (int i = 0; i < NIN; i++)
                if (gnt_vld[i])
                    ptr1_q[set_g[i*INW +: INW]] <= (pick[i*VCW +: VCW] == VCW'(NVC - 1)) ?
                                                   '0 : pick[i*VCW +: VCW] + 1'b1;
        end
    end

    // Track busy downstream VCs and the delayed second-stage fault mask.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q    <= '0;
            s2_seen_q <= '0;
        end else begin
            busy_q    <= (busy_q & ~dvc_release) | dvc_taken;
            s2_seen_q <= s2_fault;
        end
    end

endmodule

// File: rtl/va_alloc_ft_chk.sv
// Port-level checker for the allocator: grant exclusivity, request outcome,
// fault behaviour and hold-until-release. It keeps its own record of held
// downstream VCs built from grants and release pulses.
module va_alloc_ft_chk #(
    parameter int NPORT = 5,
    parameter int NVC   = 4
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic [NPORT*NVC-1:0]            req_vld,
    input logic [NPORT*NVC*$clog2(NPORT)-1:0] req_port,
    input logic [NPORT*NVC-1:0]            s1_fault,
    input logic [NPORT*NVC-1:0]            s2_fault,
    input logic [NPORT*NVC-1:0]            dvc_release,
    input logic [NPORT*NVC-1:0]            gnt_vld,
    input logic [NPORT*NVC*((NVC > 1) ? $clog2(NVC) : 1)-1:0] gnt_dvc,
    input logic [NPORT*NVC-1:0]            stall,
    input logic [NPORT*NVC-1:0]            retry
);

    localparam int NIN = NPORT * NVC;
    localparam int PW  = $clog2(NPORT);
    localparam int VCW = (NVC > 1) ? $clog2(NVC) : 1;

    logic [NIN*NIN-1:0] hits;
    logic [NIN-1:0]     granted_d;
    logic [NIN-1:0]     held_q;

    // Map each grant to its downstream VC index.
    always_comb begin
        int d;
        hits      = '0;
        granted_d = '0;
        for (int i = 0; i < NIN; i++) begin
            d = int'(req_port[i*PW +: PW]) * NVC + int'(gnt_dvc[i*VCW +: VCW]);
            if (gnt_vld[i] && d < NIN) begin
                hits[d*NIN + i] = 1'b1;
                granted_d[d]    = 1'b1;
            end
        end
    end

    // Record downstream VCs held between grant and release.
    always_ff @(posedge clk) begin
        if (!rst_n) held_q <= '0;
        else        held_q <= (held_q & ~dvc_release) | granted_d;
    end

    for (genvar i = 0; i < NIN; i++) begin : g_in
        AST_GNT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
            gnt_vld[i] |-> req_vld[i]); // R4
        AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
            req_vld[i] |-> ($countones({gnt_vld[i], stall[i], retry[i]}) == 1)); // R4
        AST_STALL_NEEDS_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
            stall[i] |-> s1_fault[i]); // R6
    end

    for (genvar d = 0; d < NIN; d++) begin : g_dvc
        AST_ONE_WINNER_PER_DVC: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(hits[d*NIN +: NIN])); // R4
        AST_FAULTY_DVC_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
            s2_fault[d] |-> !granted_d[d]); // R7
        AST_HELD_NOT_REGRANTED: assert property (@(posedge clk) disable iff (!rst_n)
            held_q[d] |-> !granted_d[d]); // R3
    end

endmodule

bind va_alloc_ft va_alloc_ft_chk #(.NPORT(NPORT), .NVC(NVC)) u_va_alloc_ft_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_vld     (req_vld),
    .req_port    (req_port),
    .s1_fault    (s1_fault),
    .s2_fault    (s2_fault),
    .dvc_release (dvc_release),
    .gnt_vld     (gnt_vld),
    .gnt_dvc     (gnt_dvc),
    .stall       (stall),
    .retry       (retry)
);

// File: tb/test_va_alloc_ft.sv
// Bench: directed corner cases plus seeded random traffic, each cycle
// compared with an allocator model built from the requirements.
module test_va_alloc_ft;

    localparam int CLK_PERIOD = 10;
    localparam int NPORT = 5;
    localparam int NVC   = 4;
    localparam int NIN   = NPORT * NVC;
    localparam int PW    = 3;
    localparam int VCW   = 2;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic [NIN-1:0]      req_vld;
    logic [NIN*PW-1:0]   req_port;
    logic [NIN*2-1:0]    vc_stage;
    logic [NIN-1:0]      s1_fault;
    logic [NIN-1:0]      s2_fault;
    logic [NIN-1:0]      dvc_release;
    logic [NIN-1:0]      gnt_vld;
    logic [NIN*VCW-1:0]  gnt_dvc;
    logic [NIN-1:0]      stall;
    logic [NIN-1:0]      retry;

    int n_checks = 0;
    int n_errors = 0;

    int m_ptr1 [NIN];
    int m_ptr2 [NIN];
    bit m_busy [NIN];
    bit m_seen [NIN];
    bit x_gnt  [NIN];
    bit x_stall[NIN];
    bit x_retry[NIN];
    bit x_dg   [NIN];
    int x_pick [NIN];
    int x_set  [NIN];
    int x_win  [NIN];

    always #(CLK_PERIOD/2) clk = ~clk;

    va_alloc_ft #(.NPORT(NPORT), .NVC(NVC)) i_va_alloc_ft (
        .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_port(req_port),
        .vc_stage(vc_stage), .s1_fault(s1_fault), .s2_fault(s2_fault),
        .dvc_release(dvc_release), .gnt_vld(gnt_vld), .gnt_dvc(gnt_dvc),
        .stall(stall), .retry(retry)
    );

    task automatic model_reset();
        for (int i = 0; i < NIN; i++) begin
            m_ptr1[i] = 0; m_ptr2[i] = 0; m_busy[i] = 0; m_seen[i] = 0;
        end
    endtask

    // Expected outcome of the current cycle from the requirements.
    task automatic model_eval();
        bit ok [NIN];
        bit go [NIN];
        int tgt[NIN];
        for (int p = 0; p < NPORT; p++) begin
            bit taken [NVC];
            for (int u = 0; u < NVC; u++) taken[u] = 0;
            for (int v = 0; v < NVC; v++) begin
                int i = p*NVC + v;
                ok[i] = 0; x_set[i] = i;
                if (!s1_fault[i]) ok[i] = 1;
                else if (req_vld[i]) begin
                    for (int u = 0; u < NVC; u++) begin
                        int j = p*NVC + u;
                        if (!ok[i] && u != v && !s1_fault[j] && vc_stage[j*2 +: 2] != 2'b10
                            && !req_vld[j] && !taken[u]) begin
                            ok[i] = 1; taken[u] = 1; x_set[i] = j;
                        end
                    end
                end
            end
        end
        for (int i = 0; i < NIN; i++) begin
            int o = int'(req_port[i*PW +: PW]);
            x_pick[i] = -1; go[i] = 0; tgt[i] = -1; x_gnt[i] = 0;
            if (req_vld[i] && ok[i] && o < NPORT) begin
                for (int k = 0; k < NVC; k++) begin
                    int c = (m_ptr1[x_set[i]] + k) % NVC;
                    if (x_pick[i] < 0 && !m_busy[o*NVC + c] && !m_seen[o*NVC + c]) x_pick[i] = c;
                end
                if (x_pick[i] >= 0) begin go[i] = 1; tgt[i] = o*NVC + x_pick[i]; end
            end
        end
        for (int d = 0; d < NIN; d++) begin
            x_win[d] = -1; x_dg[d] = 0;
            if (!s2_fault[d]) begin
                for (int k = 0; k < NIN; k++) begin
                    int i = (m_ptr2[d] + k) % NIN;
                    if (x_win[d] < 0 && go[i] && tgt[i] == d) x_win[d] = i;
                end
            end
            if (x_win[d] >= 0) begin x_gnt[x_win[d]] = 1; x_dg[d] = 1; end
        end
        for (int i = 0; i < NIN; i++) begin
            x_stall[i] = req_vld[i] && !ok[i];
            x_retry[i] = req_vld[i] && ok[i] && !x_gnt[i];
        end
    endtask

    // Clock-edge update of the model state.
    task automatic model_commit();
        for (int d = 0; d < NIN; d++)
            if (x_win[d] >= 0) m_ptr2[d] = (x_win[d] + 1) % NIN;
        for (int i = 0; i < NIN; i++)
            if (x_gnt[i]) m_ptr1[x_set[i]] = (x_pick[i] + 1) % NVC;
        for (int d = 0; d < NIN; d++) begin
            m_busy[d] = (m_busy[d] && !dvc_release[d]) || x_dg[d];
            m_seen[d] = s2_fault[d];
        end
    endtask

    // Sample outputs after inputs settle and compare with the model.
    task automatic settle(input string tag);
        logic [NIN-1:0]     eg, es, er;
        logic [NIN*VCW-1:0] ev;
        #1;
        model_eval();
        eg = '0; es = '0; er = '0; ev = '0;
        for (int i = 0; i < NIN; i++) begin
            eg[i] = x_gnt[i]; es[i] = x_stall[i]; er[i] = x_retry[i];
            if (x_gnt[i]) ev[i*VCW +: VCW] = VCW'(x_pick[i]);
        end
        n_checks++;
        if (gnt_vld !== eg || gnt_dvc !== ev || stall !== es || retry !== er) begin
            n_errors++;
            $display("FAIL %s: gnt=%h dvc=%h stall=%h retry=%h expected gnt=%h dvc=%h stall=%h retry=%h",
                     tag, gnt_vld, gnt_dvc, stall, retry, eg, ev, es, er);
        end
    endtask

    task automatic advance();
        model_commit();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic expect_val(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic clear_in();
        req_vld = '0; req_port = '0; vc_stage = '0;
        s1_fault = '0; s2_fault = '0; dvc_release = '0;
    endtask

    task automatic ask(input int i, input int o);
        req_vld[i] = 1'b1;
        req_port[i*PW +: PW] = PW'(o);
    endtask

    function automatic int dvc_of(input int i);
        return int'(gnt_dvc[i*VCW +: VCW]);
    endfunction

    task automatic rand_cycle(input bit faults, input int cyc);
        for (int i = 0; i < NIN; i++) begin
            req_vld[i] = ($urandom % 100) < 35;
            req_port[i*PW +: PW] = PW'($urandom % NPORT);
            vc_stage[i*2 +: 2] = req_vld[i] ? 2'b10 : 2'($urandom % 4);
            dvc_release[i] = (m_busy[i] && ($urandom % 4 == 0)) || ($urandom % 50 == 0);
            if (!faults) begin
                s1_fault[i] = 1'b0; s2_fault[i] = 1'b0;
            end else if (cyc % 16 == 0) begin
                s1_fault[i] = ($urandom % 6) == 0;
                s2_fault[i] = ($urandom % 8) == 0;
            end
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_checks++; n_errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd2417));
        clear_in();
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R9: quiet after reset
        clear_in(); settle("R9 idle after reset");
        expect_val("R9 no grant", int'(gnt_vld), 0);
        expect_val("R9 no stall or retry", int'(stall | retry), 0); advance();

        // R1: first free VC from pointer zero
        clear_in(); ask(0, 2); settle("R1 basic grant");
        expect_val("R1 grant", int'(gnt_vld[0]), 1);
        expect_val("R1 dvc", dvc_of(0), 0); advance();

        // R3: busy VC is skipped
        clear_in(); ask(5, 2); settle("R3 busy skip");
        expect_val("R3 skip busy dvc", dvc_of(5), 1); advance();

        // R3: release effective next cycle
        clear_in(); ask(6, 2); dvc_release[8] = 1'b1; settle("R3 release same cycle");
        expect_val("R3 release not yet visible", dvc_of(6), 2); advance();
        clear_in(); ask(7, 2); settle("R3 release next cycle");
        expect_val("R3 released dvc reused", dvc_of(7), 0); advance();

        // R2: stage-2 contention
        clear_in(); ask(1, 3); ask(2, 3); settle("R2 contention");
        expect_val("R2 winner", int'(gnt_vld[1]), 1);
        expect_val("R2 winner dvc", dvc_of(1), 0);
        expect_val("R2 loser retry", int'(retry[2]), 1); advance();
        clear_in(); ask(2, 3); settle("R2 loser retried");
        expect_val("R2 retried dvc", dvc_of(2), 1); advance();

        // R7: faulty second-stage arbiter
        clear_in(); s2_fault[16] = 1'b1; ask(10, 4); settle("R7 first fault cycle");
        expect_val("R7 retry", int'(retry[10]), 1);
        expect_val("R7 no grant", int'(gnt_vld[10]), 0); advance();
        clear_in(); s2_fault[16] = 1'b1; ask(10, 4); settle("R7 masked retry");
        expect_val("R7 other dvc", dvc_of(10), 1);
        expect_val("R7 granted", int'(gnt_vld[10]), 1); advance();

        // R5: borrowing skips a sibling in allocation
        clear_in(); s1_fault[12] = 1'b1; vc_stage[13*2 +: 2] = 2'b10; ask(12, 1);
        settle("R5 borrow");
        expect_val("R5 borrower granted", int'(gnt_vld[12]), 1);
        expect_val("R5 borrower dvc", dvc_of(12), 0); advance();
        clear_in(); ask(14, 0); settle("R5 lender pointer");
        expect_val("R5 lender pointer advanced", dvc_of(14), 1); advance();

        // R6: no lender available
        clear_in(); s1_fault[12] = 1'b1; ask(12, 1);
        vc_stage[13*2 +: 2] = 2'b10; vc_stage[14*2 +: 2] = 2'b10; vc_stage[15*2 +: 2] = 2'b10;
        settle("R6 stall");
        expect_val("R6 stall", int'(stall[12]), 1);
        expect_val("R6 no grant", int'(gnt_vld[12]), 0); advance();
        clear_in(); s1_fault[12] = 1'b1; ask(12, 1); ask(14, 1);
        vc_stage[13*2 +: 2] = 2'b10; vc_stage[15*2 +: 2] = 2'b10;
        settle("R6 lender keeps own set");
        expect_val("R6 borrower stalls", int'(stall[12]), 1);
        expect_val("R6 lender granted", int'(gnt_vld[14]), 1);
        expect_val("R6 lender dvc", dvc_of(14), 2); advance();

        // Free everything before random traffic
        clear_in(); dvc_release = '1; settle("R3 bulk release"); advance();

        // R8: fault-free random traffic against the reference
        for (int c = 0; c < 2500; c++) begin
            rand_cycle(1'b0, c);
            settle("R8 fault-free match");
            advance();
        end
        // R5 R6 R7: random traffic with faults
        for (int c = 0; c < 2500; c++) begin
            rand_cycle(1'b1, c);
            settle("R5 R6 R7 faulted traffic");
            advance();
        end

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule